// File: doc/BRIEF.md
# Byte-Lane Static Memory Port

This block models a 16-bit static memory port as a synthesizable circuit. The port has two chip enables of opposite polarity, a write enable, an output enable and one byte enable per 8-bit lane. All of these controls are active low except the second chip enable, which is active high. A fast internal clock samples the port so that the end of a write can be found as an edge. The block decodes the pins into one of four modes: standby, write, read, and active with the outputs off. The bidirectional data bus is split into a data input, a data output and one drive flag per lane.

Write data and address are held from the last sampled cycle in which a lane's write strobe was active. When that strobe releases, the lane's byte is committed to the array. A lane's write strobe is formed from the write enable, both chip enables and that lane's byte enable. Reads drive only the lanes whose byte enables are low. The array depth is set by its own parameter and is kept small. Higher address bits alias onto it. A parameter turns the second chip enable into a permanently active input, for the variant that has only one chip enable.

Top module: `bytelane_sram_port`

## Requirements
- R1: When sel1_n is high, the port is in standby and `dq_oe` is 2'b00, whatever the other inputs are.
- R2: When sel2 is low, the port is in standby, unless parameter SINGLE_CE is 1. With SINGLE_CE set to 1, sel2 is ignored and treated as high.
- R3: With both chip enables active and both byte enables high (`ub_n`=`lb_n`=1), the port is in standby and `dq_oe` is 2'b00.
- R4: With the port enabled and `wr_n` low, the port is in write mode. `dq_oe` stays 2'b00 and `rd_n` has no effect.
- R5: With the port enabled, `wr_n` high and `rd_n` low, the port reads. `dq_oe[0]` is set only when `lb_n` is low and `dq_oe[1]` only when `ub_n` is low.
- R6: With the port enabled and both `wr_n` and `rd_n` high, no lane is driven (`dq_oe`=2'b00).
- R7: A lane's byte is written when that lane's strobe goes from active to inactive. The strobe is active when sel1_n is low, sel2 is effectively high, wr_n is low and the lane's byte enable is low. The strobe can end through any of those pins. The address and data written are those of the last active sample. Lower lane is bits 7:0, upper lane is bits 15:8.
- R8: A lane whose strobe is not active keeps its stored byte. Write attempts while in standby change nothing.
- R9: Outputs follow inputs one clock after the sampling edge. Out of reset no lane is driven. A lane that is not driven reads as 0 on `dq_out`.
- R10: The array holds 2**ARRAY_AW words. The address is taken modulo that depth, so with the default ARRAY_AW=8, addresses 7 and 263 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel1_n | input | 1 | First chip enable, active low |
| sel2 | input | 1 | Second chip enable, active high |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable (bits 15:8), active low |
| lb_n | input | 1 | Lower byte enable (bits 7:0), active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data; lanes not driven are 0 |
| dq_oe | output | 2 | Per-lane drive flag, bit 0 lower, bit 1 upper |

## Verification
The checker watches the mode decode on every cycle. It confirms that either chip enable, both byte enables off, an active write enable or an idle output enable leaves the bus undriven one clock later. It confirms that each driven lane had its byte enable low. It confirms that every array commit follows an active write strobe two samples earlier. The stored contents can only be shown by the directed scenarios. These cover lane-preserving partial writes, writes ended by a byte enable rather than the write enable, ignored writes in every standby case, address aliasing and the single-enable variant, each read back through the port.

// File: rtl/blsp_pkg.sv
package blsp_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } port_mode_e;

  typedef struct packed {
    logic sel1_n;
    logic sel2;
    logic wr_n;
    logic rd_n;
    logic ub_n;
    logic lb_n;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{sel1_n: 1'b1, sel2: 1'b0, wr_n: 1'b1,
                                  rd_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1};

  function automatic logic [LANES-1:0] lane_pick(ctrl_t c);
    return {~c.ub_n, ~c.lb_n};
  endfunction

  function automatic port_mode_e decode_mode(ctrl_t c, logic single_ce);
    logic enabled;
    enabled = ~c.sel1_n & (c.sel2 | single_ce) & (|lane_pick(c));
    if (!enabled)      return MODE_STANDBY;
    else if (!c.wr_n)  return MODE_WRITE;
    else if (!c.rd_n)  return MODE_READ;
    else               return MODE_IDLE;
  endfunction

  function automatic logic [LANES-1:0] write_strobe(ctrl_t c, logic single_ce);
    return (decode_mode(c, single_ce) == MODE_WRITE) ? lane_pick(c) : '0;
  endfunction

  function automatic logic [LANES-1:0] read_drive(ctrl_t c, logic single_ce);
    return (decode_mode(c, single_ce) == MODE_READ) ? lane_pick(c) : '0;
  endfunction
endpackage

// File: rtl/blsp_sampler.sv
module blsp_sampler
  import blsp_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_t               pin_ctrl,
  input  logic [ADDR_W-1:0]   pin_addr,
  input  logic [DATA_W-1:0]   pin_data,
  output ctrl_t               cur_ctrl,
  output logic [ADDR_W-1:0]   cur_addr,
  output ctrl_t               prv_ctrl,
  output logic [ADDR_W-1:0]   prv_addr,
  output logic [DATA_W-1:0]   prv_data
);
  logic [DATA_W-1:0] cur_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ctrl <= CTRL_IDLE;
      cur_addr <= '0;
      cur_data <= '0;
      prv_ctrl <= CTRL_IDLE;
      prv_addr <= '0;
      prv_data <= '0;
    end else begin
      cur_ctrl <= pin_ctrl;
      cur_addr <= pin_addr;
      cur_data <= pin_data;
      prv_ctrl <= cur_ctrl;
      prv_addr <= cur_addr;
      prv_data <= cur_data;
    end
  end
endmodule

// File: rtl/blsp_decode.sv
module blsp_decode
  import blsp_pkg::*;
#(
  parameter bit SINGLE_CE = 1'b0
) (
  input  ctrl_t             cur_ctrl,
  input  ctrl_t             prv_ctrl,
  output port_mode_e        mode,
  output logic [LANES-1:0]  drive_lanes,
  output logic [LANES-1:0]  commit
);
  logic [LANES-1:0] cur_strobe;
  logic [LANES-1:0] prv_strobe;

  always_comb begin
    mode        = decode_mode(cur_ctrl, SINGLE_CE);
    drive_lanes = read_drive(cur_ctrl, SINGLE_CE);
    cur_strobe  = write_strobe(cur_ctrl, SINGLE_CE);
    prv_strobe  = write_strobe(prv_ctrl, SINGLE_CE);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_edge
    assign commit[g] = prv_strobe[g] & ~cur_strobe[g];
  end
endmodule

// File: rtl/blsp_array.sv
module blsp_array
  import blsp_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int ARRAY_AW = 8
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [LANES-1:0]    wr_lane,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [ARRAY_AW-1:0] rd_idx;
  logic [ARRAY_AW-1:0] wr_idx;

  assign rd_idx = ARRAY_AW'(rd_addr % ADDR_W'(DEPTH));
  assign wr_idx = ARRAY_AW'(wr_addr % ADDR_W'(DEPTH));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lane[g]) mem[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_idx];
  end
endmodule

// File: rtl/bytelane_sram_port.sv
module bytelane_sram_port
  import blsp_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int ARRAY_AW  = 8,
  parameter bit SINGLE_CE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe
);
  ctrl_t              pin_ctrl;
  ctrl_t              cur_ctrl;
  ctrl_t              prv_ctrl;
  logic [ADDR_W-1:0]  cur_addr;
  logic [ADDR_W-1:0]  prv_addr;
  logic [DATA_W-1:0]  prv_data;
  port_mode_e         mode;
  logic [LANES-1:0]   drive_lanes;
  logic [LANES-1:0]   wr_commit;
  logic [DATA_W-1:0]  array_q;

  assign pin_ctrl = '{sel1_n: sel1_n, sel2: sel2, wr_n: wr_n,
                      rd_n: rd_n, ub_n: ub_n, lb_n: lb_n};

  blsp_sampler #(.ADDR_W(ADDR_W)) u_sample (
    .clk(clk), .rst_n(rst_n),
    .pin_ctrl(pin_ctrl), .pin_addr(addr), .pin_data(dq_in),
    .cur_ctrl(cur_ctrl), .cur_addr(cur_addr),
    .prv_ctrl(prv_ctrl), .prv_addr(prv_addr), .prv_data(prv_data)
  );

  blsp_decode #(.SINGLE_CE(SINGLE_CE)) u_decode (
    .cur_ctrl(cur_ctrl), .prv_ctrl(prv_ctrl),
    .mode(mode), .drive_lanes(drive_lanes), .commit(wr_commit)
  );

  blsp_array #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_array (
    .clk(clk), .rd_addr(cur_addr), .wr_addr(prv_addr),
    .wr_data(prv_data), .wr_lane(wr_commit), .rd_data(array_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_out[g*LANE_W +: LANE_W] =
      array_q[g*LANE_W +: LANE_W] & {LANE_W{drive_lanes[g]}};
  end

  assign dq_oe = (mode == MODE_READ) ? drive_lanes : 2'b00;
endmodule

// File: rtl/blsp_checker.sv
module blsp_checker #(
  parameter bit SINGLE_CE = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel1_n,
  input logic       sel2,
  input logic       wr_n,
  input logic       rd_n,
  input logic       ub_n,
  input logic       lb_n,
  input logic [1:0] dq_oe,
  input logic [1:0] wr_commit
);
  a_r1_sel1_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel1_n) |-> dq_oe == 2'b00);

  a_r2_sel2_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!SINGLE_CE && $past(!sel2)) |-> dq_oe == 2'b00);

  a_r3_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ub_n && lb_n) |-> dq_oe == 2'b00);

  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_n) |-> dq_oe == 2'b00);

  a_r5_lower_lane: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> $past(!lb_n && !rd_n));

  a_r5_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> $past(!ub_n && !rd_n));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_n && rd_n) |-> dq_oe == 2'b00);

  a_r7_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_commit) |-> $past(!wr_n && !sel1_n, 2));

  a_r7_commit_lower: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit[0] |-> $past(!lb_n, 2));

  a_r7_commit_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit[1] |-> $past(!ub_n, 2));
endmodule

bind bytelane_sram_port blsp_checker #(.SINGLE_CE(SINGLE_CE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .wr_n(wr_n),
  .rd_n(rd_n), .ub_n(ub_n), .lb_n(lb_n), .dq_oe(dq_oe), .wr_commit(wr_commit)
);

// File: tb/sim_bytelane_sram_port.sv
module sim_bytelane_sram_port;
  localparam int AW    = 19;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic ub_n = 1'b1, lb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_out1;
  logic [1:0]  dq_oe, dq_oe1;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bytelane_sram_port #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .wr_n(wr_n),
    .rd_n(rd_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  bytelane_sram_port #(.ADDR_W(AW), .SINGLE_CE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(1'b0), .wr_n(wr_n),
    .rd_n(rd_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out1), .dq_oe(dq_oe1)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic park();
    sel1_n = 1'b1; sel2 = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic u_n, logic l_n, logic oe_n);
    sel1_n = 1'b0; sel2 = 1'b1; addr = a; dq_in = d;
    ub_n = u_n; lb_n = l_n; rd_n = oe_n; wr_n = 1'b0;
    cyc();
    chk("R4 no drive in write", {14'd0, dq_oe}, 16'd0);
    wr_n = 1'b1; rd_n = 1'b1; dq_in = ~d;
    cyc(); cyc();
    park();
    cyc();
  endtask

  task automatic do_read(logic [AW-1:0] a, logic u_n, logic l_n,
                         logic [15:0] exp_d, logic [1:0] exp_oe, string req);
    sel1_n = 1'b0; sel2 = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
    ub_n = u_n; lb_n = l_n; addr = a;
    cyc();
    chk({req, " oe"}, {14'd0, dq_oe}, {14'd0, exp_oe});
    chk({req, " data"}, dq_out, exp_d);
    park();
    cyc();
  endtask

  task automatic t_reset();
    chk("R9 reset oe", {14'd0, dq_oe}, 16'd0);
    chk("R9 reset data", dq_out, 16'd0);
  endtask

  task automatic t_full_word();
    do_write(19'd5, 16'hA55A, 1'b0, 1'b0, 1'b1);
    do_read(19'd5, 1'b0, 1'b0, 16'hA55A, 2'b11, "R5 R7 full word");
  endtask

  task automatic t_lane_write();
    do_write(19'd5, 16'h1234, 1'b1, 1'b0, 1'b1);
    do_read(19'd5, 1'b0, 1'b0, 16'hA534, 2'b11, "R8 upper kept");
    do_write(19'd5, 16'hBEEF, 1'b0, 1'b1, 1'b1);
    do_read(19'd5, 1'b0, 1'b0, 16'hBE34, 2'b11, "R8 lower kept");
  endtask

  task automatic t_lane_read();
    do_read(19'd5, 1'b0, 1'b1, 16'hBE00, 2'b10, "R5 R9 upper only");
    do_read(19'd5, 1'b1, 1'b0, 16'h0034, 2'b01, "R5 R9 lower only");
  endtask

  task automatic t_oe_ignored();
    do_write(19'd9, 16'h5AA5, 1'b0, 1'b0, 1'b0);
    do_read(19'd9, 1'b0, 1'b0, 16'h5AA5, 2'b11, "R4 write with rd_n low");
  endtask

  task automatic t_strobe_by_lane();
    sel1_n = 1'b0; sel2 = 1'b1; wr_n = 1'b0; rd_n = 1'b1;
    ub_n = 1'b1; lb_n = 1'b0; addr = 19'd9; dq_in = 16'h00C3;
    cyc();
    lb_n = 1'b1; dq_in = 16'h0000;
    cyc(); cyc();
    park(); cyc();
    do_read(19'd9, 1'b0, 1'b0, 16'h5AC3, 2'b11, "R7 ended by lb_n");
  endtask

  task automatic t_standby_writes();
    sel1_n = 1'b1; sel2 = 1'b1; wr_n = 1'b0; rd_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
    addr = 19'd5; dq_in = 16'hFFFF;
    cyc();
    chk("R1 sel1_n high", {14'd0, dq_oe}, 16'd0);
    wr_n = 1'b1; cyc();
    chk("R1 sel1_n high read", {14'd0, dq_oe}, 16'd0);
    sel1_n = 1'b0; sel2 = 1'b0; wr_n = 1'b0; cyc();
    chk("R2 sel2 low", {14'd0, dq_oe}, 16'd0);
    wr_n = 1'b1; cyc();
    chk("R2 sel2 low read", {14'd0, dq_oe}, 16'd0);
    chk("R2 single-enable ignores sel2", {14'd0, dq_oe1}, 16'h0003);
    sel2 = 1'b1; ub_n = 1'b1; lb_n = 1'b1; wr_n = 1'b0; cyc();
    chk("R3 no byte enable", {14'd0, dq_oe}, 16'd0);
    wr_n = 1'b1; cyc();
    chk("R3 no byte enable read", {14'd0, dq_oe}, 16'd0);
    park(); cyc(); cyc();
    do_read(19'd5, 1'b0, 1'b0, 16'hBE34, 2'b11, "R8 standby writes ignored");
  endtask

  task automatic t_idle();
    sel1_n = 1'b0; sel2 = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
    addr = 19'd5;
    cyc();
    chk("R6 outputs off", {14'd0, dq_oe}, 16'd0);
    chk("R6 R9 data zero", dq_out, 16'd0);
    park(); cyc();
  endtask

  task automatic t_alias();
    do_write(19'(DEPTH + 7), 16'h7777, 1'b0, 1'b0, 1'b1);
    do_read(19'd7, 1'b0, 1'b0, 16'h7777, 2'b11, "R10 alias");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_full_word();
    t_lane_write();
    t_lane_read();
    t_oe_ignored();
    t_strobe_by_lane();
    t_standby_writes();
    t_idle();
    t_alias();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule